// File: doc/BRIEF.md
# Two-Bit Clock Victim Selector

This block chooses which way of one cache set is evicted on a miss. Each way carries a two-bit reference history that behaves like a saturating counter with three levels (none, once, twice). A single hand points at one way. When a miss asks for a victim, the hand sweeps the set one way per clock. A way with a non-zero history is not chosen: it loses one level and the hand moves on. The first way found with an empty history is returned as the victim, together with that way's dirty flag, so that an outside controller can write it back before the refill.

Hit notifications carry a way index and raise that way's history by one level. Because a sweep removes only one level per visit, a way that was used twice survives two full revolutions of the hand. A sweep therefore takes at most two revolutions plus one step. Tag compare, data storage, fetch and write-back stay outside the block.

The engine is a three-state machine. IDLE waits for a miss. SCAN ages or selects the way under the hand, one way per cycle. REPORT raises the done strobe for one cycle. The transitions are: IDLE to SCAN on a miss request; SCAN to SCAN while the hand passes a non-empty way; SCAN to REPORT when a victim is selected; and REPORT to IDLE unconditionally.

Top module: `clk2_victim_engine`

## Requirements
- R1: After reset every history is 00, the hand is 0, and busy and done are low.
- R2: The history of way w appears on `hist_flat[2w+1:2w]`, with bit 0 as the first reference bit and bit 1 as the second. A hit on way w moves that history from 00 to 01, from 01 to 11, and leaves 11 unchanged, one clock after the hit is sampled.
- R3: A miss request sampled in IDLE makes busy high from the next cycle. Busy stays high through the cycle in which done is high. During SCAN the hand advances by exactly one way per cycle.
- R4: In SCAN, a way under the hand whose history is 11 becomes 01, and one whose history is 01 becomes 00. The hand then moves to the next way.
- R5: In SCAN, a way under the hand whose history is 00 and that is not hit in that cycle is selected. Done is high for exactly the next cycle. In that cycle `victim_way` holds that way's index and `victim_dirty` holds `dirty_in` bit for that way as sampled at selection.
- R6: When a way is selected, its history becomes 01 and the hand moves to the following way, wrapping from the last way to way 0. Outside SCAN the hand does not move.
- R7: A hit on the way under the hand in a SCAN cycle takes priority. That way's history is incremented with saturation, it is neither aged nor selected, and the hand moves on.
- R8: A miss request while busy is high, including the done cycle, has no effect. The engine returns to IDLE one cycle after done and starts no further search.
- R9: With every history at 11 and the hand at way h, done rises 2*WAYS+1 cycles after the cycle that samples the miss request, and the victim is way h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | A hit is reported this cycle |
| hit_way | input | $clog2(WAYS) | Way index of the reported hit |
| miss_req | input | 1 | Request a victim search |
| dirty_in | input | WAYS | Per-way dirty flags from the tag store |
| busy | output | 1 | A search is in progress or being reported |
| done | output | 1 | One-cycle strobe: victim outputs are valid |
| victim_way | output | $clog2(WAYS) | Index of the selected way |
| victim_dirty | output | 1 | Dirty flag of the selected way |
| hand | output | $clog2(WAYS) | Current hand position |
| hist_flat | output | 2*WAYS | Two-bit history of every way |

## Verification
The bench fills every way to the saturated level and checks that the sweep takes two full revolutions plus one step and returns the way it started on. A design that aged two levels per visit would finish in one revolution, and one that never aged would hang. A hit is aimed at the way under the hand in the middle of a sweep. A design without hit priority would age that way or even evict it, and the bench would see the wrong history or the wrong victim. Miss requests are also raised during the sweep and in the done cycle. A design that accepted them would stay busy after done or start a second sweep. The hand wrap and the refill level of 01 are checked against the bench's own model over a long random run with interleaved hits.

// File: rtl/clk2_pkg.sv
package clk2_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_REPORT = 2'd2
    } eng_state_t;

    localparam logic [1:0] HIST_EMPTY = 2'b00;
    localparam logic [1:0] HIST_ONCE  = 2'b01;
    localparam logic [1:0] HIST_TWICE = 2'b11;

    // raise a history by one level, saturating at two
    function automatic logic [1:0] hist_raise(input logic [1:0] h);
        return {h[0], 1'b1};
    endfunction

    // drop a history by one level, floor at zero
    function automatic logic [1:0] hist_drop(input logic [1:0] h);
        return {1'b0, h[1]};
    endfunction

endpackage

// File: rtl/clk2_way_hist.sv
module clk2_way_hist
    import clk2_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic       age,
    input  logic       fill,
    output logic [1:0] hist
);

    logic [1:0] hist_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= HIST_EMPTY;
        end else if (hit) begin
            hist_q <= hist_raise(hist_q);
        end else if (fill) begin
            hist_q <= HIST_ONCE;
        end else if (age) begin
            hist_q <= hist_drop(hist_q);
        end
    end

    assign hist = hist_q;

    // R2: only the three thermometer levels ever occur
    p_legal_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hist != 2'b10);

    // R2: a hit leaves the first bit set, and the second set if the first was
    p_hit_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (hist[0] && (hist[1] || !$past(hist[0]))));

    // R4: an aging step without a hit removes exactly one level
    p_age_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age && !hit && !fill) |=> (!hist[1] && (hist[0] == $past(hist[1]))));

    // R6: a refilled way starts at one level
    p_fill_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill && !hit) |=> (hist == HIST_ONCE));

endmodule

// File: rtl/clk2_hand_fsm.sv
module clk2_hand_fsm
    import clk2_pkg::*;
#(
    parameter int WAYS  = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_req,
    input  logic [1:0]       hand_hist,
    input  logic             hit_at_hand,
    input  logic             dirty_at_hand,
    output logic [WAY_W-1:0] hand,
    output logic             age_en,
    output logic             fill_en,
    output logic             busy,
    output logic             done,
    output logic [WAY_W-1:0] victim_way,
    output logic             victim_dirty
);

    eng_state_t       state_q, state_d;
    logic [WAY_W-1:0] hand_q, hand_d;
    logic [WAY_W-1:0] victim_q;
    logic             vdirty_q;
    logic             select;

    // next state and step decode
    always_comb begin
        state_d = state_q;
        hand_d  = hand_q;
        select  = 1'b0;
        age_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (miss_req) begin
                    state_d = ST_SCAN;
                end
            end
            ST_SCAN: begin
                hand_d = (hand_q == WAY_W'(WAYS - 1)) ? '0 : hand_q + 1'b1;
                if (!hit_at_hand) begin
                    if (hand_hist == HIST_EMPTY) begin
                        select  = 1'b1;
                        state_d = ST_REPORT;
                    end else begin
                        age_en = 1'b1;
                    end
                end
            end
            ST_REPORT: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            hand_q   <= '0;
            victim_q <= '0;
            vdirty_q <= 1'b0;
        end else begin
            state_q <= state_d;
            hand_q  <= hand_d;
            if (select) begin
                victim_q <= hand_q;
                vdirty_q <= dirty_at_hand;
            end
        end
    end

    // outputs
    always_comb begin
        fill_en      = select;
        busy         = (state_q != ST_IDLE);
        done         = (state_q == ST_REPORT);
        hand         = hand_q;
        victim_way   = victim_q;
        victim_dirty = vdirty_q;
    end

    // R3: every scan cycle moves the hand by one way, with wrap
    p_hand_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |=>
            (hand_q == (($past(hand_q) == WAY_W'(WAYS - 1)) ? '0 : $past(hand_q) + 1'b1)));

    // R6: the hand holds still outside a scan
    p_hand_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SCAN) |=> $stable(hand_q));

    // R5: an empty way under the hand without a hit ends the search
    p_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && hand_hist == HIST_EMPTY && !hit_at_hand) |=> done);

    // R5: done is a single-cycle strobe
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: after done the engine always goes idle, whatever miss_req does
    p_report_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R7: a hit on the hand way never selects it
    p_hit_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && hit_at_hand) |=> !done);

endmodule

// File: rtl/clk2_victim_engine.sv
module clk2_victim_engine
    import clk2_pkg::*;
#(
    parameter int WAYS  = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit_valid,
    input  logic [WAY_W-1:0]   hit_way,
    input  logic               miss_req,
    input  logic [WAYS-1:0]    dirty_in,
    output logic               busy,
    output logic               done,
    output logic [WAY_W-1:0]   victim_way,
    output logic               victim_dirty,
    output logic [WAY_W-1:0]   hand,
    output logic [2*WAYS-1:0]  hist_flat
);

    logic [1:0]       hist [WAYS];
    logic [WAY_W-1:0] hand_w;
    logic             age_en;
    logic             fill_en;
    logic             hit_at_hand;

    assign hit_at_hand = hit_valid && (hit_way == hand_w);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic at_hand;
        logic way_hit;

        assign at_hand = (hand_w == WAY_W'(w));
        assign way_hit = hit_valid && (hit_way == WAY_W'(w));

        clk2_way_hist u_hist (
            .clk  (clk),
            .rst_n(rst_n),
            .hit  (way_hit),
            .age  (age_en && at_hand),
            .fill (fill_en && at_hand),
            .hist (hist[w])
        );

        assign hist_flat[2*w +: 2] = hist[w];
    end

    clk2_hand_fsm #(.WAYS(WAYS)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .miss_req     (miss_req),
        .hand_hist    (hist[hand_w]),
        .hit_at_hand  (hit_at_hand),
        .dirty_at_hand(dirty_in[hand_w]),
        .hand         (hand_w),
        .age_en       (age_en),
        .fill_en      (fill_en),
        .busy         (busy),
        .done         (done),
        .victim_way   (victim_way),
        .victim_dirty (victim_dirty)
    );

    assign hand = hand_w;

    // R3: a miss sampled while idle makes the engine busy
    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && miss_req) |=> busy);

    // R6: the selected way reads back one level at the done strobe
    p_victim_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(hit_valid)) |-> (hist[victim_way] == HIST_ONCE));

endmodule

// File: tb/test_clk2_victim_engine.sv
module test_clk2_victim_engine;

    localparam int WAYS  = 4;
    localparam int WAY_W = $clog2(WAYS);

    logic               clk;
    logic               rst_n;
    logic               hit_valid;
    logic [WAY_W-1:0]   hit_way;
    logic               miss_req;
    logic [WAYS-1:0]    dirty_in;
    logic               busy;
    logic               done;
    logic [WAY_W-1:0]   victim_way;
    logic               victim_dirty;
    logic [WAY_W-1:0]   hand;
    logic [2*WAYS-1:0]  hist_flat;

    clk2_victim_engine #(.WAYS(WAYS)) i_clk2_victim_engine (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_way(hit_way),
        .miss_req(miss_req), .dirty_in(dirty_in), .busy(busy), .done(done),
        .victim_way(victim_way), .victim_dirty(victim_dirty), .hand(hand),
        .hist_flat(hist_flat)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model: level counts 0..2, state 0 idle, 1 scan, 2 report
    int m_hist [WAYS];
    int m_hand;
    int m_state;
    int m_victim;
    int m_vdirty;

    function automatic int enc(input int c);
        return (c == 0) ? 0 : ((c == 1) ? 1 : 3);
    endfunction

    function automatic int hist_of(input logic [2*WAYS-1:0] f, input int w);
        return int'(f[2*w +: 2]);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int w = 0; w < WAYS; w++) m_hist[w] = 0;
        m_hand = 0; m_state = 0; m_victim = 0; m_vdirty = 0;
    endtask

    task automatic model_step(input bit hv, input int hw, input bit mr,
                              input logic [WAYS-1:0] dr);
        int nh [WAYS];
        for (int w = 0; w < WAYS; w++) nh[w] = m_hist[w];
        if (m_state == 1) begin
            if (!(hv && hw == m_hand)) begin
                if (m_hist[m_hand] == 0) begin
                    m_victim = m_hand;
                    m_vdirty = int'(dr[m_hand]);
                    nh[m_hand] = 1;
                    m_state = 2;
                end else begin
                    nh[m_hand] = m_hist[m_hand] - 1;
                end
            end
            m_hand = (m_hand + 1) % WAYS;
        end else if (m_state == 2) begin
            m_state = 0;
        end else if (mr) begin
            m_state = 1;
        end
        if (hv) nh[hw] = (m_hist[hw] >= 2) ? 2 : m_hist[hw] + 1;
        for (int w = 0; w < WAYS; w++) m_hist[w] = nh[w];
    endtask

    task automatic compare_all();
        for (int w = 0; w < WAYS; w++)
            chk(hist_of(hist_flat, w) == enc(m_hist[w]), "R2,R4", "history",
                hist_of(hist_flat, w), enc(m_hist[w]));
        chk(int'(hand) == m_hand, "R6", "hand", int'(hand), m_hand);
        chk(busy == (m_state != 0), "R3", "busy", int'(busy), int'(m_state != 0));
        chk(done == (m_state == 2), "R5", "done", int'(done), int'(m_state == 2));
        if (m_state == 2) begin
            chk(int'(victim_way) == m_victim, "R5", "victim_way", int'(victim_way), m_victim);
            chk(int'(victim_dirty) == m_vdirty, "R5", "victim_dirty", int'(victim_dirty), m_vdirty);
        end
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input bit hv, input int hw, input bit mr, input logic [WAYS-1:0] dr);
        hit_valid = hv;
        hit_way   = WAY_W'(hw);
        miss_req  = mr;
        dirty_in  = dr;
        @(posedge clk);
        model_step(hv, hw, mr, dr);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_cyc();
        cyc(1'b0, 0, 1'b0, '0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed_val;
        int n;
        int p;
        int start_h;
        seed_val = $urandom(32'h0C10C4A5);
        rst_n = 1'b0; hit_valid = 1'b0; hit_way = '0; miss_req = 1'b0; dirty_in = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(hist_flat == '0, "R1", "hist_flat", int'(hist_flat), 0);
        chk(hand == '0, "R1", "hand", int'(hand), 0);
        chk(!busy && !done, "R1", "busy|done", int'(busy | done), 0);

        // R2: saturating raise on way 1
        cyc(1'b1, 1, 1'b0, '0);
        chk(hist_of(hist_flat, 1) == 1, "R2", "one hit", hist_of(hist_flat, 1), 1);
        cyc(1'b1, 1, 1'b0, '0);
        cyc(1'b1, 1, 1'b0, '0);
        chk(hist_of(hist_flat, 1) == 3, "R2", "saturate", hist_of(hist_flat, 1), 3);

        // R9: all ways at the top level, worst-case sweep
        for (int w = 0; w < WAYS; w++) begin
            cyc(1'b1, w, 1'b0, '0);
            cyc(1'b1, w, 1'b0, '0);
        end
        start_h = int'(hand);
        cyc(1'b0, 0, 1'b1, '1);
        chk(busy == 1'b1, "R3", "busy after miss", int'(busy), 1);
        n = 0;
        while (!done && n < 50) begin
            cyc(1'b0, 0, 1'b0, '1);
            n++;
        end
        chk(n == 2 * WAYS + 1, "R9", "sweep length", n, 2 * WAYS + 1);
        chk(int'(victim_way) == start_h, "R9", "victim", int'(victim_way), start_h);
        chk(victim_dirty == 1'b1, "R5", "dirty flag", int'(victim_dirty), 1);
        chk(int'(hand) == (start_h + 1) % WAYS, "R6", "hand after select",
            int'(hand), (start_h + 1) % WAYS);
        chk(hist_of(hist_flat, start_h) == 1, "R6", "refill level",
            hist_of(hist_flat, start_h), 1);

        // R7: hit on the hand way during a sweep; R8: misses while busy
        p = int'(hand);
        cyc(1'b1, p, 1'b0, '0);
        cyc(1'b1, p, 1'b0, '0);
        cyc(1'b0, 0, 1'b1, '0);
        cyc(1'b1, p, 1'b1, '0);
        chk(hist_of(hist_flat, p) == 3, "R7", "hand way kept", hist_of(hist_flat, p), 3);
        n = 0;
        while (!done && n < 50) begin
            cyc(1'b0, 0, 1'b1, '0);
            n++;
        end
        chk(int'(victim_way) != p, "R7", "hit way not evicted", int'(victim_way), (p + 1) % WAYS);
        cyc(1'b0, 0, 1'b1, '0);
        chk(busy == 1'b0, "R8", "miss in done cycle", int'(busy), 0);
        idle_cyc();
        chk(busy == 1'b0, "R8", "no second sweep", int'(busy), 0);

        // constrained random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom_range(0, 99) < 45), $urandom_range(0, WAYS - 1),
                ($urandom_range(0, 99) < 25), WAYS'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule